// File: doc/BRIEF.md
# Adapter Configuration EEPROM Loader

This block fetches the adapter's start-up configuration from a serial EEPROM once the adapter's enable sequence has completed. It does not drive the EEPROM wires. It talks to a separate byte-read engine through a simple request/response port. The loader gives the engine an address and a one-cycle request. The engine answers with a one-cycle done pulse and the data byte.

Eight bytes are fetched, always in the same order. The first is the ring-speed byte. Any nonzero value selects 4 Mb/s and zero selects 16 Mb/s, and the result drives a speed-select pin. The second is the memory-size byte, which is scaled by 128 to give the on-board memory in kilobytes. The last six are the station address, read from six consecutive locations starting at a base address. A valid flag announces that the whole set has been loaded.

Top module: `cfg_rom_loader`

## Requirements
- R1: After reset `rd_req`, `cfg_valid`, `speed_sel`, `ram_kb` and `station_addr` are all 0.
- R2: No read request is issued until `enable_done` has been sampled high. While it stays low the block waits indefinitely.
- R3: Exactly eight requests are issued, at addresses RATE_ADDR, SIZE_ADDR, then MAC_BASE, MAC_BASE+1, ..., MAC_BASE+5. Each `rd_req` lasts one cycle. `rd_addr` holds steady until the matching `rd_done`, and the next request follows only after it.
- R4: `speed_sel` becomes 1 when the byte at RATE_ADDR is nonzero (4 Mb/s) and 0 when it is zero (16 Mb/s).
- R5: `ram_kb` (16 bits) equals the byte at SIZE_ADDR times 128, with no truncation up to 255*128 = 32640.
- R6: `station_addr[47:40]` holds the byte from MAC_BASE, and each following byte sits 8 bits lower. `station_addr[7:0]` holds the byte from MAC_BASE+5.
- R7: `cfg_valid` rises in the cycle after the eighth `rd_done`. It then stays high until reset, and no further requests are issued.
- R8: A `rd_done` pulse that arrives while no request is outstanding is ignored and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_done | input | 1 | Adapter enable sequence has finished |
| rd_req | output | 1 | One-cycle read request to the byte-read engine |
| rd_addr | output | 8 | EEPROM address of the current read |
| rd_done | input | 1 | One-cycle pulse: `rd_data` is valid |
| rd_data | input | 8 | Byte returned by the engine |
| speed_sel | output | 1 | 1 = 4 Mb/s ring, 0 = 16 Mb/s ring |
| ram_kb | output | 16 | Adapter memory size in kilobytes |
| station_addr | output | 48 | Station address, first-read byte in the top octet |
| cfg_valid | output | 1 | All eight bytes loaded |

## Verification
The table-driven part loads four EEPROM images and checks every output for each one:
- A zero speed byte against a nonzero one with only its top bit set. This separates a true nonzero test from a test of the low bit.
- Size bytes 0, 1, 0x80 and 0xFF. These expose a wrong scale factor and a result truncated to too few bits.
- Station addresses whose six bytes are all distinct. This exposes a reversed or shifted byte order.
- The exact request address sequence and count for every image.

Directed cases hold the enable low for a long stretch, and inject stray done pulses both before the enable and after loading has finished.

// File: rtl/cfg_rom_loader.sv
module cfg_rom_loader #(
  parameter int ADDR_W = 8,
  parameter int MAC_LEN = 6,
  parameter int MEM_W = 16,
  parameter int SCALE_LOG2 = 7,
  parameter logic [ADDR_W-1:0] RATE_ADDR = 8'h12,
  parameter logic [ADDR_W-1:0] SIZE_ADDR = 8'h13,
  parameter logic [ADDR_W-1:0] MAC_BASE = 8'h20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable_done,
  output logic                 rd_req,
  output logic [ADDR_W-1:0]    rd_addr,
  input  logic                 rd_done,
  input  logic [7:0]           rd_data,
  output logic                 speed_sel,
  output logic [MEM_W-1:0]     ram_kb,
  output logic [8*MAC_LEN-1:0] station_addr,
  output logic                 cfg_valid
);
  localparam int NREADS = MAC_LEN + 2;
  localparam int IDX_W = $clog2(NREADS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NREADS - 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_t;
  state_t state;
  logic [IDX_W-1:0] idx;
  logic [7:0] size_q;

  assign rd_req    = (state == S_ISSUE);
  assign cfg_valid = (state == S_DONE);
  assign ram_kb    = MEM_W'(size_q) << SCALE_LOG2;

  always_comb begin
    if (idx == '0)
      rd_addr = RATE_ADDR;
    else if (idx == IDX_W'(1))
      rd_addr = SIZE_ADDR;
    else
      rd_addr = MAC_BASE + ADDR_W'(idx) - ADDR_W'(2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      idx          <= '0;
      size_q       <= '0;
      speed_sel    <= 1'b0;
      station_addr <= '0;
    end else begin
      case (state)
        S_IDLE:  if (enable_done) state <= S_ISSUE;
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (rd_done) begin
          if (idx == '0)
            speed_sel <= (rd_data != 8'h00);
          else if (idx == IDX_W'(1))
            size_q <= rd_data;
          else
            station_addr <= {station_addr[8*MAC_LEN-9:0], rd_data};
          if (idx == LAST) begin
            state <= S_DONE;
          end else begin
            idx   <= idx + IDX_W'(1);
            state <= S_ISSUE;
          end
        end
        default: state <= S_DONE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_rom_loader_chk.sv
module cfg_rom_loader_chk #(
  parameter int ADDR_W = 8,
  parameter int MAC_LEN = 6,
  parameter int MEM_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 enable_done,
  input logic                 rd_req,
  input logic [ADDR_W-1:0]    rd_addr,
  input logic                 rd_done,
  input logic [7:0]           rd_data,
  input logic                 speed_sel,
  input logic [MEM_W-1:0]     ram_kb,
  input logic [8*MAC_LEN-1:0] station_addr,
  input logic                 cfg_valid
);
  logic seen_en, pending;
  logic [3:0] req_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_en <= 1'b0;
      pending <= 1'b0;
      req_cnt <= '0;
    end else begin
      if (enable_done) seen_en <= 1'b1;
      if (rd_req) begin
        pending <= 1'b1;
        req_cnt <= req_cnt + 4'd1;
      end else if (rd_done) begin
        pending <= 1'b0;
      end
    end
  end

  // R2
  no_early_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_en |-> !rd_req);

  // R3
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !rd_req);

  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> $stable(rd_addr));

  // R4
  speed_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && rd_done && req_cnt == 4'd1) |=> (speed_sel == ($past(rd_data) != 8'h00)));

  // R5
  size_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && rd_done && req_cnt == 4'd2) |=> (ram_kb == MEM_W'({$past(rd_data), 7'b0})));

  // R7
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> cfg_valid);

  // R7
  no_read_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (!rd_req && req_cnt == 4'(MAC_LEN + 2)));

  // R8
  stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !pending) |=> ($stable(speed_sel) && $stable(ram_kb) && $stable(station_addr)));
endmodule

bind cfg_rom_loader cfg_rom_loader_chk #(.ADDR_W(ADDR_W), .MAC_LEN(MAC_LEN), .MEM_W(MEM_W)) u_chk (.*);

// File: tb/tb_cfg_rom_loader.sv
module tb_cfg_rom_loader;
  localparam int LAT = 3;
  logic clk = 0, rst_n = 0, enable_done = 0;
  logic rd_req, rd_done, rd_done_eng = 0, stray = 0;
  logic [7:0] rd_addr, rd_data = 0, addr_l = 0;
  logic speed_sel, cfg_valid;
  logic [15:0] ram_kb;
  logic [47:0] station_addr;
  logic [7:0] mem [256];
  logic [7:0] log_a [16];
  int nreq = 0, cnt = 0, checks = 0, errors = 0;

  always #10 clk = ~clk;
  assign rd_done = rd_done_eng | stray;

  cfg_rom_loader dut (.clk(clk), .rst_n(rst_n), .enable_done(enable_done), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_done(rd_done), .rd_data(rd_data), .speed_sel(speed_sel),
    .ram_kb(ram_kb), .station_addr(station_addr), .cfg_valid(cfg_valid));

  always @(posedge clk) begin
    rd_done_eng <= 1'b0;
    if (!rst_n) begin
      cnt <= 0; nreq <= 0;
    end else if (rd_req) begin
      cnt <= LAT; addr_l <= rd_addr;
      if (nreq < 16) log_a[nreq] <= rd_addr;
      nreq <= nreq + 1;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin rd_done_eng <= 1'b1; rd_data <= mem[addr_l]; end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    enable_done = 0; rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic wait_valid();
    int n = 0;
    while (!cfg_valid && n < 2000) begin @(negedge clk); n++; end
    if (!cfg_valid) chk("R7 watchdog", 0, 1);
  endtask

  task automatic pulse_stray();
    @(negedge clk); stray = 1;
    @(negedge clk); stray = 0;
    @(negedge clk);
  endtask

  // {rate byte, size byte, station address}
  localparam logic [63:0] VEC [4] = '{
    {8'h00, 8'h00, 48'h0011_2233_4455},
    {8'h80, 8'h01, 48'h0200_5E10_2030},
    {8'h01, 8'hFF, 48'hA1B2_C3D4_E5F6},
    {8'h00, 8'h80, 48'hFEDC_BA98_7654}
  };

  task automatic load(input logic [63:0] v);
    mem[8'h12] = v[63:56];
    mem[8'h13] = v[55:48];
    for (int k = 0; k < 6; k++) mem[8'h20 + k] = v[47 - 8*k -: 8];
  endtask

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 8'(a ^ 8'h5A);
    do_reset();
    // R1 reset state
    chk("R1 rd_req", rd_req, 0);
    chk("R1 cfg_valid", cfg_valid, 0);
    chk("R1 speed_sel", speed_sel, 0);
    chk("R1 ram_kb", ram_kb, 0);
    chk("R1 station_addr", station_addr, 0);

    for (int i = 0; i < 4; i++) begin
      load(VEC[i]);
      do_reset();
      repeat (4) @(negedge clk);
      enable_done = 1;
      wait_valid();
      chk("R4 speed_sel", speed_sel, VEC[i][63:56] != 0);
      chk("R5 ram_kb", ram_kb, 64'(VEC[i][55:48]) * 128);
      chk("R6 station_addr", station_addr, VEC[i][47:0]);
      chk("R7 cfg_valid", cfg_valid, 1);
      chk("R3 request count", nreq, 8);
      chk("R3 addr 0", log_a[0], 8'h12);
      chk("R3 addr 1", log_a[1], 8'h13);
      for (int k = 0; k < 6; k++) chk("R3 mac addr", log_a[2 + k], 8'h20 + k);
    end

    // R7: stays valid, no more reads
    repeat (40) @(negedge clk);
    chk("R7 still valid", cfg_valid, 1);
    chk("R7 no extra reads", nreq, 8);
    // R8: stray done after loading
    pulse_stray();
    chk("R8 station unchanged", station_addr, VEC[3][47:0]);
    chk("R8 size unchanged", ram_kb, 64'h4000);
    chk("R8 no extra reads", nreq, 8);

    // R2: long hold of enable low, plus stray done while idle
    load(VEC[2]);
    do_reset();
    repeat (50) @(negedge clk);
    chk("R2 no reads before enable", nreq, 0);
    chk("R2 not valid", cfg_valid, 0);
    pulse_stray();
    chk("R8 idle stray station", station_addr, 0);
    chk("R8 idle stray speed", speed_sel, 0);
    chk("R8 idle stray reads", nreq, 0);
    enable_done = 1;
    @(negedge clk); enable_done = 0;
    wait_valid();
    chk("R2 enable pulse starts load", station_addr, VEC[2][47:0]);
    chk("R5 max size", ram_kb, 16'd32640);
    chk("R4 nonzero rate", speed_sel, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule